// File: doc/BRIEF.md
# Shared Arithmetic, Logic and Compare Unit

This block is the 16-bit execution unit of a small single-cycle processor. One combinational unit serves arithmetic, bitwise logic and relational comparison, so the datapath needs no separate comparator. The decoder picks a class of operation. A 4-bit function code then picks the logic or compare subfunction inside that class.

A comparison returns a one-word truth value: 16'h0001 when true, 16'h0000 when false. Ordering is signed two's complement. The surrounding processor writes that word into its condition register for a later conditional branch. For the logic class, the decoder feeds the function code from instruction bits [11:8]. For the compare class, it feeds the code from bits [3:0]. The unit only sees the code itself.

Rotation is limited to one position per operation; software loops for longer rotates. The unit has no clock and no state. Every result settles from the current inputs.

Top module: `alu_share`

## Requirements
- R1: With `op_sel` = 3'b000 (sum), `res` equals `opnd_a + opnd_b` modulo 2^16.
- R2: With `op_sel` = 3'b001 (difference), `res` equals `opnd_a - opnd_b` modulo 2^16.
- R3: With `op_sel` = 3'b010 (bitwise), `fn_code` selects the function: 4'b0000 AND, 4'b0001 OR, 4'b0010 NAND, 4'b0011 NOR, 4'b0100 XOR, 4'b0101 XNOR.
- R4: With `op_sel` = 3'b010, `fn_code` values 4'b0110 through 4'b1111 give `res` = 16'h0000.
- R5: With `op_sel` = 3'b011 (relational), `fn_code` selects a signed test of `opnd_a` against `opnd_b`: 4'b0000 greater, 4'b0001 less, 4'b0010 greater-or-equal, 4'b0011 less-or-equal, 4'b0100 equal, 4'b0101 not-equal. `res` is 16'h0001 when the test holds and 16'h0000 otherwise.
- R6: With `op_sel` = 3'b011, `fn_code` values 4'b0110 through 4'b1111 give `res` = 16'h0000.
- R7: With `op_sel` = 3'b100 (rotate), `res` is `opnd_a` rotated left by exactly one bit, so bit 15 moves to bit 0.
- R8: `op_sel` values 3'b101, 3'b110 and 3'b111 give `res` = 16'h0000.
- R9: In the rotate class, `opnd_b` and `fn_code` have no effect on `res`. In the sum and difference classes, `fn_code` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 3 | Operation class from the decoder |
| fn_code | input | 4 | Logic or compare subfunction code |
| res | output | 16 | Result word |

## Verification
The bench drives signed boundaries: 16'h7FFF against 16'h8000, where an unsigned comparator inverts greater and less, and equal operands, where a swapped strict and non-strict test gives the wrong answer. Carry and borrow out of bit 15 check that sums and differences wrap instead of saturating or widening. A rotate of 16'h8001 shows whether bit 15 returns to bit 0 or is lost as in a shift. The unused subfunction and class codes, and changes to ignored inputs, would expose a design that aliases codes or leaks a stale operand into the result.

// File: rtl/alu_share_pkg.sv
package alu_share_pkg;
    localparam int DATA_W = 16;
    localparam int OP_W   = 3;
    localparam int FN_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_SUM   = 3'b000,
        OPC_DIFF  = 3'b001,
        OPC_BITW  = 3'b010,
        OPC_REL   = 3'b011,
        OPC_ROT   = 3'b100
    } op_class_e;

    typedef enum logic [FN_W-1:0] {
        BW_AND  = 4'b0000,
        BW_OR   = 4'b0001,
        BW_NAND = 4'b0010,
        BW_NOR  = 4'b0011,
        BW_XOR  = 4'b0100,
        BW_XNOR = 4'b0101
    } bitw_fn_e;

    typedef enum logic [FN_W-1:0] {
        RL_GT = 4'b0000,
        RL_LT = 4'b0001,
        RL_GE = 4'b0010,
        RL_LE = 4'b0011,
        RL_EQ = 4'b0100,
        RL_NE = 4'b0101
    } rel_fn_e;
endpackage

// File: rtl/alu_share_addsub.sv
module alu_share_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         minus,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = minus ? ~b : b;
        y     = a + b_eff + {{(W-1){1'b0}}, minus};
    end
endmodule

// File: rtl/alu_share_bitw.sv
module alu_share_bitw #(
    parameter int W  = 16,
    parameter int FW = 4
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [FW-1:0] fn,
    output logic [W-1:0]  y
);
    import alu_share_pkg::*;

    always_comb begin
        unique case (fn)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_NAND: y = ~(a & b);
            BW_NOR:  y = ~(a | b);
            BW_XOR:  y = a ^ b;
            BW_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_share_rel.sv
module alu_share_rel #(
    parameter int W  = 16,
    parameter int FW = 4
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [FW-1:0] fn,
    output logic [W-1:0]  y
);
    import alu_share_pkg::*;

    logic lt_s, eq_s, hit;

    always_comb begin
        lt_s = $signed(a) < $signed(b);
        eq_s = (a == b);
        unique case (fn)
            RL_GT:   hit = !lt_s && !eq_s;
            RL_LT:   hit = lt_s;
            RL_GE:   hit = !lt_s;
            RL_LE:   hit = lt_s || eq_s;
            RL_EQ:   hit = eq_s;
            RL_NE:   hit = !eq_s;
            default: hit = 1'b0;
        endcase
        y = {{(W-1){1'b0}}, hit};
    end
endmodule

// File: rtl/alu_share.sv
module alu_share #(
    parameter int WIDTH = alu_share_pkg::DATA_W,
    parameter int OPW   = alu_share_pkg::OP_W,
    parameter int FNW   = alu_share_pkg::FN_W
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [OPW-1:0]   op_sel,
    input  logic [FNW-1:0]   fn_code,
    output logic [WIDTH-1:0] res
);
    import alu_share_pkg::*;

    logic [WIDTH-1:0] arith_y, bitw_y, rel_y, rot_y;
    logic             minus;

    assign minus = (op_sel == OPC_DIFF);

    alu_share_addsub #(.W(WIDTH)) u_addsub (
        .a(opnd_a), .b(opnd_b), .minus(minus), .y(arith_y)
    );

    alu_share_bitw #(.W(WIDTH), .FW(FNW)) u_bitw (
        .a(opnd_a), .b(opnd_b), .fn(fn_code), .y(bitw_y)
    );

    alu_share_rel #(.W(WIDTH), .FW(FNW)) u_rel (
        .a(opnd_a), .b(opnd_b), .fn(fn_code), .y(rel_y)
    );

    assign rot_y = {opnd_a[WIDTH-2:0], opnd_a[WIDTH-1]};

    always_comb begin
        unique case (op_sel)
            OPC_SUM, OPC_DIFF: res = arith_y;
            OPC_BITW:          res = bitw_y;
            OPC_REL:           res = rel_y;
            OPC_ROT:           res = rot_y;
            default:           res = '0;
        endcase
    end
endmodule

// File: rtl/alu_share_chk.sv
module alu_share_chk #(
    parameter int WIDTH = 16,
    parameter int OPW   = 3,
    parameter int FNW   = 4
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [OPW-1:0]   op_sel,
    input logic [FNW-1:0]   fn_code,
    input logic [WIDTH-1:0] res
);
    logic [WIDTH-1:0] low_mask;
    assign low_mask = {1'b0, {(WIDTH-1){1'b1}}};

    always_comb begin
        if (op_sel == 3'b000)
            AST_SUM_INVERSE: assert (res - opnd_a == opnd_b); // R1
        if (op_sel == 3'b001)
            AST_DIFF_INVERSE: assert (res + opnd_b == opnd_a); // R2
        if (op_sel == 3'b010 && fn_code == 4'b0100)
            AST_XOR_INVERSE: assert ((res ^ opnd_b) == opnd_a); // R3
        if (op_sel == 3'b010 && fn_code > 4'b0101)
            AST_BITW_SPARE_ZERO: assert (res == '0); // R4
        if (op_sel == 3'b011)
            AST_REL_ONE_BIT: assert ((res >> 1) == '0); // R5
        if (op_sel == 3'b011 && fn_code > 4'b0101)
            AST_REL_SPARE_ZERO: assert (res == '0); // R6
        if (op_sel == 3'b100)
            AST_ROT_KEEPS_ONES: assert ($countones(res) == $countones(opnd_a)); // R7
        if (op_sel == 3'b100)
            AST_ROT_WRAP_BIT: assert (((res >> 1) & low_mask) == (opnd_a & low_mask)); // R7
        if (op_sel > 3'b100)
            AST_SPARE_CLASS_ZERO: assert (res == '0); // R8
    end
endmodule

bind alu_share alu_share_chk #(.WIDTH(WIDTH), .OPW(OPW), .FNW(FNW)) u_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .fn_code(fn_code), .res(res)
);

// File: tb/alu_share_bench.sv
module alu_share_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic [3:0]  fn_code = '0;
    logic [15:0] res;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    sb_item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_share u_alu_share (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
        .fn_code(fn_code), .res(res)
    );

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [2:0] op, input logic [3:0] fn);
        logic t;
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: case (fn)
                4'd0: return a & b;
                4'd1: return a | b;
                4'd2: return ~(a & b);
                4'd3: return ~(a | b);
                4'd4: return a ^ b;
                4'd5: return ~(a ^ b);
                default: return 16'h0000;
            endcase
            3'd3: begin
                case (fn)
                    4'd0: t = $signed(a) >  $signed(b);
                    4'd1: t = $signed(a) <  $signed(b);
                    4'd2: t = $signed(a) >= $signed(b);
                    4'd3: t = $signed(a) <= $signed(b);
                    4'd4: t = a == b;
                    4'd5: t = a != b;
                    default: t = 1'b0;
                endcase
                return {15'd0, t};
            end
            3'd4: return {a[14:0], a[15]};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] op, input logic [3:0] fn, input string tag);
        sb_item_t it;
        @(posedge clk);
        opnd_a  = a;
        opnd_b  = b;
        op_sel  = op;
        fn_code = fn;
        it.exp  = model(a, b, op, fn);
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_checks++;
            if (res !== it.exp) begin
                n_fail++;
                $display("FAIL %s: res=%h expected=%h", it.tag, res, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: res=%h expected=completion", res);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 3'd0, 4'd0, "R1 idle zero");
        drive(16'h1234, 16'h0101, 3'd0, 4'd0, "R1 add");
        drive(16'hFFFF, 16'h0002, 3'd0, 4'd0, "R1 add wrap");
        drive(16'h1234, 16'h0101, 3'd0, 4'd9, "R9 add ignores fn");
        drive(16'h0005, 16'h0003, 3'd1, 4'd0, "R2 sub");
        drive(16'h0000, 16'h0001, 3'd1, 4'd0, "R2 sub wrap");
        drive(16'h8000, 16'h0001, 3'd1, 4'd7, "R9 sub ignores fn");
        for (int f = 0; f < 6; f++)
            drive(16'hF0CC, 16'h3CAA, 3'd2, 4'(f), "R3 logic fn");
        for (int f = 6; f < 16; f++)
            drive(16'hFFFF, 16'h0F0F, 3'd2, 4'(f), "R4 logic spare");
        for (int f = 0; f < 6; f++) begin
            drive(16'h7FFF, 16'h8000, 3'd3, 4'(f), "R5 cmp max vs min");
            drive(16'h8000, 16'h7FFF, 3'd3, 4'(f), "R5 cmp min vs max");
            drive(16'hFFFE, 16'hFFFE, 3'd3, 4'(f), "R5 cmp equal");
            drive(16'hFFFF, 16'h0001, 3'd3, 4'(f), "R5 cmp neg vs pos");
        end
        for (int f = 6; f < 16; f++)
            drive(16'h0003, 16'h0003, 3'd3, 4'(f), "R6 cmp spare");
        drive(16'h8001, 16'h0000, 3'd4, 4'd0, "R7 rotate wrap");
        drive(16'h4000, 16'h0000, 3'd4, 4'd0, "R7 rotate top bit");
        drive(16'h8001, 16'hFFFF, 3'd4, 4'd5, "R9 rotate ignores b and fn");
        drive(16'h0001, 16'h1234, 3'd4, 4'd15, "R9 rotate ignores b");
        for (int o = 5; o < 8; o++)
            drive(16'hFFFF, 16'hFFFF, 3'(o), 4'd0, "R8 spare class");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule